// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block decides which of five interrupt requests, if any, turns into a call at the next instruction boundary. The five requests are two external pins (active low), two timer overflow pulses and a serial request. It holds three configuration registers:

- an enable register, with one bit per source and a global enable bit;
- a level register, which places each source in a high or a low priority class;
- a sense register, which picks edge or level detection for each external pin.

Requests are captured on a machine-cycle strobe. They are arbitrated on the strobe that follows. A winning request produces a one-clock call pulse and a fixed vector address.

The CPU side supplies three status inputs on every strobe: whether this is the final cycle of the current instruction, whether the instruction is a return from interrupt, and whether it writes the enable or level register. The block keeps one in-service bit for each priority class. A return from interrupt releases the most urgent active class. The timers, the serial port, the stack and the CPU itself are outside the block.

Top module: `irq_vector_arb`

## Requirements
- R1: After reset, all three configuration registers are zero, `call_req` is 0, `call_vec` is 0, both `in_service` bits are 0 and both `ext_flag` bits are 0.
- R2: The vector is VEC_BASE + 8*index. The source indices are: external pin 0 = 0, timer 0 = 1, external pin 1 = 2, timer 1 = 3, serial = 4. With the defaults this gives 0x03, 0x0B, 0x13, 0x1B and 0x23.
- R3: When several requests of the same class are pending together, the lowest source index is served first.
- R4: A source is served only if its enable bit and the global enable bit are both set. A request that is pending while disabled stays pending if it is a latched flag.
- R5: A request present at strobe k is captured at strobe k. It can cause `call_req` no earlier than the clock after strobe k+1. `call_req` lasts exactly one clock.
- R6: No call is issued on a strobe unless `instr_last`=1, `instr_reti`=0 and `instr_cfg_wr`=0 on that strobe.
- R7: A request that was blocked and has gone away by the time the block lifts is never served.
- R8: With sense bit 1, an external pin sampled high on one strobe and low on the next sets its flag. With sense bit 0, the flag equals the inverse of the last strobe sample of the pin.
- R9: Serving a request clears the timer flag and the edge-mode external flag. It leaves level-mode external flags and the serial request untouched, so a request that is still held is served again after the return.
- R10: The serial request is the OR of `ser_rx_flag` and `ser_tx_flag`.
- R11: A high-class request preempts an active low-class service. Nothing is served while a high-class service is active. A low-class request waits while a low-class service is active.
- R12: On a strobe with `instr_last`=1 and `instr_reti`=1, the high in-service bit is cleared if it is set; otherwise the low one is cleared.
- R13: A write with `cfg_sel`=0 loads the enable register: bit 5 is the global enable and bits 4..0 are the source enables. `cfg_sel`=1 loads the level register from bits 4..0, where 1 means high. `cfg_sel`=2 loads the sense register from bits 1..0, with bit 0 for pin 0. `cfg_sel`=3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mcycle_stb | input | 1 | One-clock strobe marking the end of each machine cycle |
| ext_pin_n | input | 2 | External interrupt pins, active low |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_rx_flag | input | 1 | Serial receive-done flag, held by the serial port |
| ser_tx_flag | input | 1 | Serial transmit-done flag, held by the serial port |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register selected by the write |
| cfg_wdata | input | 6 | Write data |
| instr_last | input | 1 | Current cycle is the last of the instruction |
| instr_reti | input | 1 | Current instruction is a return from interrupt |
| instr_cfg_wr | input | 1 | Current instruction writes the enable or level register |
| call_req | output | 1 | One-clock call request |
| call_vec | output | ADDR_W | Vector address of the last call |
| in_service | output | 2 | Bit 1: high class active, bit 0: low class active |
| ext_flag | output | 2 | External request flags |

## Verification
The bench builds the block with its default parameters: 16-bit vectors at base 0x0003 with a step of 8. It drives the strobe on every third clock, which makes the capture-then-arbitrate delay and the blocked-and-forgotten cases visible within a few clocks. Each external source is run in both sense modes. One sequence nests a high-class call inside a low-class one and then unwinds it through successive returns. Another keeps a level request, and then the serial request, held across a return to show that neither is cleared on vectoring.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;

    localparam int NSRC    = 5;
    localparam int SRC_W   = 3;
    localparam int N_PAIR  = 2;
    localparam int CFG_W   = NSRC + 1;
    localparam int SRC_SER = 4;

    typedef enum logic [1:0] {
        CFG_ENABLE = 2'd0,
        CFG_LEVEL  = 2'd1,
        CFG_SENSE  = 2'd2,
        CFG_NONE   = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic              ea;
        logic [NSRC-1:0]   en;
        logic [NSRC-1:0]   hi;
        logic [N_PAIR-1:0] edge_sel;
    } cfg_t;

    typedef struct packed {
        logic             valid;
        logic             high;
        logic [SRC_W-1:0] idx;
    } grant_t;

    // Returns {found, index of lowest set bit}
    function automatic logic [SRC_W:0] first_set(input logic [NSRC-1:0] v);
        logic [SRC_W:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) r = {1'b1, SRC_W'(i)};
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_ext_sense.sv
module irq_ext_sense (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic hw_clr,
    output logic flag_q,
    output logic flag_d
);
    logic pin_q;

    always_comb begin
        if (edge_mode) flag_d = (pin_q & ~pin_n) | (flag_q & ~hw_clr);
        else           flag_d = ~pin_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q  <= 1'b1;
            flag_q <= 1'b0;
        end else if (stb) begin
            pin_q  <= pin_n;
            flag_q <= flag_d;
        end
    end

    p_edge_sets_r8: assert property (@(posedge clk) disable iff (rst)
        (stb && edge_mode && pin_q && !pin_n) |=> flag_q);
    p_level_tracks_r8: assert property (@(posedge clk) disable iff (rst)
        (stb && !edge_mode) |=> (flag_q == !$past(pin_n)));
    p_holds_between_r5: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(flag_q));

endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_vector_pkg::*;
(
    input  logic [NSRC-1:0] req,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] hi_sel,
    input  logic            ea,
    input  logic            allow,
    input  logic            busy_hi,
    input  logic            busy_lo,
    output grant_t          grant
);
    logic [SRC_W:0] f_hi;
    logic [SRC_W:0] f_lo;

    always_comb begin
        f_hi  = first_set(req & en & hi_sel);
        f_lo  = first_set(req & en & ~hi_sel);
        grant = '0;
        if (allow && ea) begin
            if (!busy_hi && f_hi[SRC_W]) begin
                grant.valid = 1'b1;
                grant.high  = 1'b1;
                grant.idx   = f_hi[SRC_W-1:0];
            end else if (!busy_hi && !busy_lo && f_lo[SRC_W]) begin
                grant.valid = 1'b1;
                grant.high  = 1'b0;
                grant.idx   = f_lo[SRC_W-1:0];
            end
        end
    end

endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic take_high,
    input  logic reti_ev,
    output logic in_hi,
    output logic in_lo
);
    always_ff @(posedge clk) begin
        if (rst) begin
            in_hi <= 1'b0;
            in_lo <= 1'b0;
        end else if (take) begin
            if (take_high) in_hi <= 1'b1;
            else           in_lo <= 1'b1;
        end else if (reti_ev) begin
            if (in_hi) in_hi <= 1'b0;
            else       in_lo <= 1'b0;
        end
    end

    p_no_hi_nest_r11: assert property (@(posedge clk) disable iff (rst)
        take |-> !in_hi);
    p_lo_needs_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (take && !take_high) |-> !in_lo);
    p_take_not_on_reti_r6: assert property (@(posedge clk) disable iff (rst)
        take |-> !reti_ev);
    p_reti_pops_hi_r12: assert property (@(posedge clk) disable iff (rst)
        (reti_ev && in_hi) |=> (!in_hi && $stable(in_lo)));
    p_reti_pops_lo_r12: assert property (@(posedge clk) disable iff (rst)
        (reti_ev && !in_hi && in_lo) |=> !in_lo);

endmodule

// File: rtl/irq_vector_arb.sv
module irq_vector_arb
    import irq_vector_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mcycle_stb,
    input  logic [N_PAIR-1:0]       ext_pin_n,
    input  logic [N_PAIR-1:0]       tmr_ovf,
    input  logic                    ser_rx_flag,
    input  logic                    ser_tx_flag,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_sel,
    input  logic [CFG_W-1:0]        cfg_wdata,
    input  logic                    instr_last,
    input  logic                    instr_reti,
    input  logic                    instr_cfg_wr,
    output logic                    call_req,
    output logic [ADDR_W-1:0]       call_vec,
    output logic [1:0]              in_service,
    output logic [N_PAIR-1:0]       ext_flag
);
    cfg_t              cfg_q;
    cfg_sel_e          sel;
    logic [NSRC-1:0]   req_nxt;
    logic [NSRC-1:0]   snap_q;
    logic [NSRC-1:0]   clr_vec;
    logic [N_PAIR-1:0] tf_q;
    logic [N_PAIR-1:0] tf_d;
    logic              allow;
    logic              reti_ev;
    logic              in_hi;
    logic              in_lo;
    grant_t            grant;

    assign sel     = cfg_sel_e'(cfg_sel);
    assign allow   = mcycle_stb & instr_last & ~instr_reti & ~instr_cfg_wr;
    assign reti_ev = mcycle_stb & instr_last & instr_reti;
    assign clr_vec = grant.valid ? (NSRC'(1) << grant.idx) : '0;

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            case (sel)
                CFG_ENABLE: begin
                    cfg_q.ea <= cfg_wdata[CFG_W-1];
                    cfg_q.en <= cfg_wdata[NSRC-1:0];
                end
                CFG_LEVEL: cfg_q.hi       <= cfg_wdata[NSRC-1:0];
                CFG_SENSE: cfg_q.edge_sel <= cfg_wdata[N_PAIR-1:0];
                default: ;
            endcase
        end
    end

    // external pin / timer pairs share the interleaved source order
    for (genvar g = 0; g < N_PAIR; g++) begin : g_pair
        irq_ext_sense u_sense (
            .clk       (clk),
            .rst       (rst),
            .stb       (mcycle_stb),
            .pin_n     (ext_pin_n[g]),
            .edge_mode (cfg_q.edge_sel[g]),
            .hw_clr    (clr_vec[2*g]),
            .flag_q    (ext_flag[g]),
            .flag_d    (req_nxt[2*g])
        );

        assign tf_d[g]         = tmr_ovf[g] | (tf_q[g] & ~clr_vec[2*g+1]);
        assign req_nxt[2*g+1]  = tf_d[g];

        p_timer_clr_r9: assert property (@(posedge clk) disable iff (rst)
            (grant.valid && grant.idx == SRC_W'(2*g+1) && !tmr_ovf[g]) |=> !tf_q[g]);
    end

    assign req_nxt[SRC_SER] = ser_rx_flag | ser_tx_flag;

    always_ff @(posedge clk) begin
        if (rst) tf_q <= '0;
        else     tf_q <= tf_d;
    end

    // capture on one strobe, arbitrate on the next
    always_ff @(posedge clk) begin
        if (rst)             snap_q <= '0;
        else if (mcycle_stb) snap_q <= req_nxt;
    end

    irq_pick u_pick (
        .req     (snap_q),
        .en      (cfg_q.en),
        .hi_sel  (cfg_q.hi),
        .ea      (cfg_q.ea),
        .allow   (allow),
        .busy_hi (in_hi),
        .busy_lo (in_lo),
        .grant   (grant)
    );

    irq_nest_track u_nest (
        .clk       (clk),
        .rst       (rst),
        .take      (grant.valid),
        .take_high (grant.high),
        .reti_ev   (reti_ev),
        .in_hi     (in_hi),
        .in_lo     (in_lo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            call_req <= 1'b0;
            call_vec <= '0;
        end else begin
            call_req <= grant.valid;
            if (grant.valid)
                call_vec <= ADDR_W'(VEC_BASE) + ADDR_W'(grant.idx) * ADDR_W'(VEC_STEP);
        end
    end

    assign in_service = {in_hi, in_lo};

    p_call_boundary_r6: assert property (@(posedge clk) disable iff (rst)
        call_req |-> $past(mcycle_stb && instr_last && !instr_reti && !instr_cfg_wr));
    p_call_needs_ea_r4: assert property (@(posedge clk) disable iff (rst)
        call_req |-> $past(cfg_q.ea));
    p_snap_on_stb_r5: assert property (@(posedge clk) disable iff (rst)
        !mcycle_stb |=> $stable(snap_q));

endmodule

// File: tb/sim_irq_vector_arb.sv
`timescale 1ns/1ps
module sim_irq_vector_arb;
    localparam int MC = 3;
    localparam int WD = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mcycle_stb = 1'b0;
    logic [1:0] ext_pin_n = 2'b11;
    logic [1:0] tmr_ovf = 2'b00;
    logic       ser_rx_flag = 1'b0;
    logic       ser_tx_flag = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [5:0] cfg_wdata = 6'd0;
    logic       instr_last = 1'b1;
    logic       instr_reti = 1'b0;
    logic       instr_cfg_wr = 1'b0;
    logic        call_req;
    logic [15:0] call_vec;
    logic [1:0]  in_service;
    logic [1:0]  ext_flag;

    irq_vector_arb u0 (
        .clk(clk), .rst(rst), .mcycle_stb(mcycle_stb), .ext_pin_n(ext_pin_n),
        .tmr_ovf(tmr_ovf), .ser_rx_flag(ser_rx_flag), .ser_tx_flag(ser_tx_flag),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .instr_last(instr_last), .instr_reti(instr_reti), .instr_cfg_wr(instr_cfg_wr),
        .call_req(call_req), .call_vec(call_vec), .in_service(in_service), .ext_flag(ext_flag)
    );

    always #4 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    int    mc_cnt = 0;
    string cur_req = "R1";
    int    got[$];
    bit    started = 0;

    // behavioural reference state
    bit       m_ea, m_hi, m_lo, m_call;
    bit [4:0] m_en, m_pri;
    bit [1:0] m_mode;
    int       m_vec;
    bit       m_flag[4];
    bit       m_snap[5];
    bit       m_pinq[2];

    always @(negedge clk) begin
        if (rst) mc_cnt = 0;
        else mc_cnt = (mc_cnt + 1) % MC;
        mcycle_stb = (!rst && mc_cnt == MC - 1);
    end

    always @(posedge clk) begin
        int win;
        bit p;
        if (rst) begin
            m_ea = 0; m_hi = 0; m_lo = 0; m_call = 0; m_vec = 0;
            m_en = 0; m_pri = 0; m_mode = 0;
            foreach (m_flag[i]) m_flag[i] = 0;
            foreach (m_snap[i]) m_snap[i] = 0;
            m_pinq[0] = 1; m_pinq[1] = 1;
            started = 1;
        end else begin
            m_call = 0;
            win = -1;
            if (mcycle_stb) begin
                if (instr_last && !instr_reti && !instr_cfg_wr && m_ea) begin
                    if (!m_hi)
                        for (int i = 0; i < 5; i++)
                            if (win < 0 && m_snap[i] && m_en[i] && m_pri[i]) win = i;
                    if (win < 0 && !m_hi && !m_lo)
                        for (int i = 0; i < 5; i++)
                            if (win < 0 && m_snap[i] && m_en[i] && !m_pri[i]) win = i;
                end
                if (win >= 0) begin
                    m_call = 1;
                    m_vec  = 3 + 8 * win;
                    if (m_pri[win]) m_hi = 1; else m_lo = 1;
                end
                if (instr_last && instr_reti) begin
                    if (m_hi) m_hi = 0; else m_lo = 0;
                end
                for (int e = 0; e < 2; e++) begin
                    p = ext_pin_n[e];
                    if (m_mode[e]) begin
                        if (win == 2 * e) m_flag[2*e] = 0;
                        if (m_pinq[e] && !p) m_flag[2*e] = 1;
                    end else begin
                        m_flag[2*e] = !p;
                    end
                    m_pinq[e] = p;
                end
                for (int t = 0; t < 2; t++) begin
                    if (win == 2 * t + 1) m_flag[2*t+1] = 0;
                    if (tmr_ovf[t]) m_flag[2*t+1] = 1;
                end
                for (int i = 0; i < 4; i++) m_snap[i] = m_flag[i];
                m_snap[4] = ser_rx_flag | ser_tx_flag;
            end else begin
                for (int t = 0; t < 2; t++) if (tmr_ovf[t]) m_flag[2*t+1] = 1;
            end
            if (cfg_we) begin
                case (cfg_sel)
                    2'd0: begin m_ea = cfg_wdata[5]; m_en = cfg_wdata[4:0]; end
                    2'd1: m_pri  = cfg_wdata[4:0];
                    2'd2: m_mode = cfg_wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (started) begin
            n_chk++;
            if (call_req !== m_call || call_vec !== m_vec[15:0] ||
                in_service !== {m_hi, m_lo} ||
                ext_flag !== {m_flag[2], m_flag[0]}) begin
                n_fail++;
                $display("FAIL %s t=%0t call/vec/svc/flag got %b/%h/%b/%b exp %b/%h/%b/%b",
                         cur_req, $time, call_req, call_vec, in_service, ext_flag,
                         m_call, m_vec[15:0], {m_hi, m_lo}, {m_flag[2], m_flag[0]});
            end
            if (call_req === 1'b1) got.push_back(int'(call_vec));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mc(input int n);
        tick(n * MC);
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [5:0] d);
        cfg_sel = s; cfg_wdata = d; cfg_we = 1'b1;
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic reti_mc();
        instr_reti = 1'b1;
        tick(MC);
        instr_reti = 1'b0;
    endtask

    task automatic pulse_tmr(input logic [1:0] m);
        tmr_ovf = m;
        tick(1);
        tmr_ovf = 2'b00;
    endtask

    // expected vectors packed one per byte, first call in bits 7..0
    task automatic check_seq(input string tag, input int n, input logic [31:0] exp);
        n_chk++;
        if (got.size() != n) begin
            n_fail++;
            $display("FAIL %s call count got %0d exp %0d", tag, got.size(), n);
        end else begin
            for (int i = 0; i < n; i++) begin
                n_chk++;
                if (got[i] != int'(exp[8*i +: 8])) begin
                    n_fail++;
                    $display("FAIL %s call %0d vector got %h exp %h", tag, i, got[i], exp[8*i +: 8]);
                end
            end
        end
        got.delete();
    endtask

    initial begin
        cur_req = "R1";
        tick(5);
        rst = 1'b0;
        mc(3);
        check_seq("R1", 0, 32'h0);

        cur_req = "R13";
        cfg_write(2'd3, 6'h3F);
        cfg_write(2'd2, 6'h03);
        cfg_write(2'd1, 6'h00);
        cfg_write(2'd0, 6'h3F);
        mc(2);

        // serial request stays set across a return
        cur_req = "R10";
        ser_tx_flag = 1'b1;
        mc(3);
        reti_mc();
        mc(3);
        ser_tx_flag = 1'b0;
        mc(2);
        reti_mc();
        mc(3);
        check_seq("R9", 2, 32'h0000_2323);

        // simultaneous same-class requests
        cur_req = "R3";
        ext_pin_n[0] = 1'b0;
        pulse_tmr(2'b11);
        mc(3); reti_mc();
        ext_pin_n[0] = 1'b1;
        mc(3); reti_mc();
        mc(3); reti_mc();
        cur_req = "R5";
        ext_pin_n[1] = 1'b0;
        mc(3); reti_mc();
        ext_pin_n[1] = 1'b1;
        mc(3);
        check_seq("R2", 4, 32'h131B_0B03);

        // global and per-source enables
        cur_req = "R4";
        cfg_write(2'd0, 6'h1F);
        pulse_tmr(2'b01);
        mc(4);
        check_seq("R4", 0, 32'h0);
        cfg_write(2'd0, 6'h3F);
        mc(3); reti_mc();
        cfg_write(2'd0, 6'h3D);
        pulse_tmr(2'b01);
        mc(4);
        cfg_write(2'd0, 6'h3F);
        mc(3); reti_mc();
        mc(2);
        check_seq("R4", 2, 32'h0000_0B0B);

        // blocked then withdrawn request is lost
        cur_req = "R7";
        cfg_write(2'd2, 6'h01);
        instr_last = 1'b0;
        ext_pin_n[1] = 1'b0;
        mc(4);
        ext_pin_n[1] = 1'b1;
        mc(3);
        instr_last = 1'b1;
        mc(3);
        check_seq("R7", 0, 32'h0);
        cur_req = "R6";
        instr_cfg_wr = 1'b1;
        ext_pin_n[1] = 1'b0;
        mc(4);
        check_seq("R6", 0, 32'h0);
        instr_cfg_wr = 1'b0;
        mc(3);
        ext_pin_n[1] = 1'b1;
        mc(2); reti_mc();
        mc(3);
        check_seq("R6", 1, 32'h0000_0013);

        // nesting of classes
        cur_req = "R11";
        cfg_write(2'd2, 6'h03);
        cfg_write(2'd1, 6'h09);
        ser_rx_flag = 1'b1;
        mc(3);
        ser_rx_flag = 1'b0;
        pulse_tmr(2'b10);
        mc(3);
        ext_pin_n[0] = 1'b0;
        pulse_tmr(2'b01);
        mc(3);
        ext_pin_n[0] = 1'b1;
        cur_req = "R12";
        reti_mc(); mc(3);
        reti_mc(); mc(3);
        check_seq("R11", 3, 32'h0003_1B23);
        reti_mc(); mc(3);
        reti_mc(); mc(2);
        check_seq("R12", 1, 32'h0000_000B);

        // level sense is not cleared on vectoring
        cur_req = "R8";
        cfg_write(2'd2, 6'h00);
        cfg_write(2'd1, 6'h00);
        ext_pin_n[0] = 1'b0;
        mc(3); reti_mc();
        mc(3);
        ext_pin_n[0] = 1'b1;
        mc(2); reti_mc();
        mc(3);
        check_seq("R8", 2, 32'h0000_0303);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule